// File: doc/BRIEF.md
# Class-Sorted Per-Thread Instruction Buffer

This block decouples an instruction front end from an execution back end. Each cycle the front end may offer one write group of up to six instructions for a single hardware thread. Every instruction carries a payload and a 3-bit execution-unit class. The buffer sorts each instruction into the queue for its class, inside storage owned by the writing thread. There are six class queues per thread and two threads, each queue sixteen entries deep, for 192 entries in total.

The back end names one thread per cycle and sees the oldest entries of each of that thread's class queues on twelve read ports. The ports are spread unevenly across the classes to match the issue width of each unit type. The back end removes entries by raising a take bit on the ports it consumes. The writing thread and the reading thread are chosen independently. A group is accepted whole or not at all. Each thread has a flush that empties its six queues in one cycle.

Top module: `ibuf_class_split`

## Requirements
- R1: After a synchronous active-low reset every queue of every thread is empty: `rd_valid` is all zero for either value of `rd_tid`, and `wr_ready` is high while no flush is raised.
- R2: Class codes are 0 memory, 1 integer, 2 ALU, 3 floating point, 4 branch, 5 NOP. Read ports are grouped by class: ports 0-1 memory, 2-3 integer, 4-5 ALU, 6-7 floating point, 8-10 branch, 11 NOP. An accepted instruction appears only on the ports of its own class.
- R3: Within one class queue of one thread, entries leave in arrival order. Within a group, a lower lane counts as older than a higher lane.
- R4: For the selected thread, the ports of a class present the oldest entries of that queue: the lowest port holds the oldest. A port is valid only if every lower port of the same class is valid.
- R5: Entries are visible only while `rd_tid` names their thread. A write to one thread and a pop from the other can occur in the same cycle.
- R6: A group is accepted only if, for every class, the valid lanes of that class fit in the free space of that class's queue of `wr_tid`. Otherwise `wr_ready` is low and no lane of the group is stored, including lanes of classes that had room.
- R7: A valid lane with class code 6 or 7 is discarded. `wr_bad_class` is high in the same cycle when such a group is accepted. The legal lanes of that group are stored.
- R8: Raising `flush[t]` empties all six queues of thread t at the next clock edge and leaves the other thread's entries intact. A write to thread t in that cycle is refused (`wr_ready` low). The refill after a flush starts from an empty queue.
- R9: A take bit on a valid port removes that entry at the clock edge. The next cycle the class ports show the following entries.
- R10: Each class queue of each thread holds exactly 16 entries. A group that would bring it to 17 is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | A write group is offered |
| wr_tid | input | 1 | Thread that owns the write group |
| wr_mask | input | 6 | Per-lane valid bits of the group |
| wr_class | input | 18 | 3-bit class code per lane, lane 0 in the low bits |
| wr_payload | input | 192 | 32-bit payload per lane, lane 0 in the low bits |
| wr_ready | output | 1 | The offered group fits and will be accepted |
| wr_bad_class | output | 1 | An accepted group carried an illegal class code |
| rd_tid | input | 1 | Thread whose queues are read this cycle |
| rd_take | input | 12 | Per-port consume bits |
| rd_valid | output | 12 | Per-port entry present |
| rd_payload | output | 384 | 32-bit payload per read port, port 0 in the low bits |
| flush | input | 2 | Per-thread flush |

## Verification
The bench goes after the group that is refused while only one of its classes is short of room. A design that checks the space lane by lane would store the lanes that fit, and a later drain would show a stray memory entry or an extra NOP. It fills one NOP queue to exactly 16 and then offers one more entry. An off-by-one in the free-space test would either refuse the fourth group or accept the seventeenth, and the sixteen-step drain would show it. It mixes illegal class codes with legal lanes, which catches a design that drops the whole group or stores the illegal lanes. It raises a flush during a write to the same thread, which catches a design that keeps stale pointers or lets the write in. It pops one thread while the other is written, which catches crosstalk between the thread partitions.

// File: rtl/ibuf_pkg.sv
// Package ibuf_pkg
// Shared class codes and the read-port layout of the class-split buffer.
// Assumes six unit classes with fixed issue widths; port bases follow class order.
package ibuf_pkg;

    localparam int CLS_N = 6;
    localparam int CLS_W = 3;

    typedef enum logic [CLS_W-1:0] {
        UC_MEM = 3'd0,
        UC_INT = 3'd1,
        UC_ALU = 3'd2,
        UC_FP  = 3'd3,
        UC_BR  = 3'd4,
        UC_NOP = 3'd5
    } ucls_e;

    // Issue width (read ports) of one class.
    function automatic int cls_ports(input int c);
        case (c)
            4:       return 3;
            5:       return 1;
            default: return 2;
        endcase
    endfunction

    // First read port of one class: the sum of the widths of the classes before it.
    function automatic int cls_base(input int c);
        int acc;
        acc = 0;
        for (int i = 0; i < c; i++) acc += cls_ports(i);
        return acc;
    endfunction

    localparam int RD_PORTS = cls_base(CLS_N);
    localparam int MAX_POP  = 3;

endpackage

// File: rtl/ibuf_enq_sorter.sv
// Module ibuf_enq_sorter
// Splits one write group into per-class lists and compacts each list in lane order,
// so that a lower lane lands first. Lanes with a code at or above CLS_N are flagged and left out.
// Purely combinational; assumes LANES is small (one adder chain per class).
module ibuf_enq_sorter
    import ibuf_pkg::*;
#(
    parameter int LANES = 6,
    parameter int PAY_W = 32,
    localparam int LC_W = $clog2(LANES + 1)
) (
    input  logic [LANES-1:0]                       lane_vld,
    input  logic [LANES-1:0][CLS_W-1:0]            lane_cls,
    input  logic [LANES-1:0][PAY_W-1:0]            lane_pay,
    output logic [CLS_N-1:0][LC_W-1:0]             cls_cnt,
    output logic [CLS_N-1:0][LANES-1:0][PAY_W-1:0] cls_data,
    output logic [LANES-1:0]                       bad_lane
);

    logic [LC_W-1:0] fill;

    // Per class: walk the lanes in order and pack matching payloads from slot 0 upward.
    always_comb begin
        fill     = '0;
        cls_cnt  = '0;
        cls_data = '0;
        for (int c = 0; c < CLS_N; c++) begin
            fill = '0;
            for (int l = 0; l < LANES; l++) begin
                if (lane_vld[l] && lane_cls[l] == CLS_W'(c)) begin
                    cls_data[c][fill] = lane_pay[l];
                    fill = fill + 1'b1;
                end
            end
            cls_cnt[c] = fill;
        end
    end

    // Flag the valid lanes whose class code has no queue.
    always_comb begin
        for (int l = 0; l < LANES; l++)
            bad_lane[l] = lane_vld[l] && (lane_cls[l] >= CLS_W'(CLS_N));
    end

endmodule

// File: rtl/ibuf_class_queue.sv
// Module ibuf_class_queue
// One circular FIFO for one class of one thread. It accepts up to PUSH_N entries and
// releases up to POP_N entries per cycle, and shows its POP_N oldest entries.
// Assumes DEPTH is a power of two and that the caller never pushes beyond the free space
// or pops beyond the count. Flush clears the pointers and ignores pushes and pops.
module ibuf_class_queue #(
    parameter int DEPTH   = 16,
    parameter int PAY_W   = 32,
    parameter int PUSH_N  = 6,
    parameter int POP_N   = 2,
    parameter int POPC_W  = 2,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int PSHC_W = $clog2(PUSH_N + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          flush,
    input  logic [PSHC_W-1:0]             push_cnt,
    input  logic [PUSH_N-1:0][PAY_W-1:0]  push_data,
    input  logic [POPC_W-1:0]             pop_cnt,
    output logic [POP_N-1:0][PAY_W-1:0]   head_data,
    output logic [CNT_W-1:0]              count,
    output logic [CNT_W-1:0]              free
);

    logic [PAY_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wptr;
    logic [PTR_W-1:0] rptr;

    // Store the compacted push entries at consecutive slots from the write pointer.
    always_ff @(posedge clk) begin
        for (int k = 0; k < PUSH_N; k++) begin
            if (!flush && PSHC_W'(k) < push_cnt)
                mem[wptr + PTR_W'(k)] <= push_data[k];
        end
    end

    // Advance the pointers and the occupancy; reset and flush return to empty.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            wptr  <= wptr + PTR_W'(push_cnt);
            rptr  <= rptr + PTR_W'(pop_cnt);
            count <= count + CNT_W'(push_cnt) - CNT_W'(pop_cnt);
        end
    end

    // Present the oldest POP_N slots, oldest on index 0.
    always_comb begin
        for (int k = 0; k < POP_N; k++)
            head_data[k] = mem[rptr + PTR_W'(k)];
    end

    assign free = CNT_W'(DEPTH) - count;

    AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rst_n) CNT_W'(push_cnt) <= free);  // R10
    AST_COUNT_BOUND:  assert property (@(posedge clk) disable iff (!rst_n) count <= CNT_W'(DEPTH));    // R10
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) CNT_W'(pop_cnt) <= count);  // R9
    AST_FLUSH_EMPTY:  assert property (@(posedge clk) disable iff (!rst_n) flush |=> count == '0);     // R8

endmodule

// File: rtl/ibuf_class_split.sv
// Module ibuf_class_split
// Decoupling instruction buffer: one write group per cycle for one thread is sorted into
// that thread's six class queues; one thread per cycle is read on twelve class-mapped ports.
// Assumes THREADS >= 2, and that the back end raises take bits only on a prefix of a class's ports.
module ibuf_class_split
    import ibuf_pkg::*;
#(
    parameter int THREADS = 2,
    parameter int DEPTH   = 16,
    parameter int LANES   = 6,
    parameter int PAY_W   = 32,
    localparam int TID_W  = $clog2(THREADS),
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int LC_W   = $clog2(LANES + 1),
    localparam int POPC_W = $clog2(MAX_POP + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_valid,
    input  logic [TID_W-1:0]          wr_tid,
    input  logic [LANES-1:0]          wr_mask,
    input  logic [LANES*CLS_W-1:0]    wr_class,
    input  logic [LANES*PAY_W-1:0]    wr_payload,
    output logic                      wr_ready,
    output logic                      wr_bad_class,
    input  logic [TID_W-1:0]          rd_tid,
    input  logic [RD_PORTS-1:0]       rd_take,
    output logic [RD_PORTS-1:0]       rd_valid,
    output logic [RD_PORTS*PAY_W-1:0] rd_payload,
    input  logic [THREADS-1:0]        flush
);

    logic [LANES-1:0][CLS_W-1:0]            s_cls;
    logic [LANES-1:0][PAY_W-1:0]            s_pay;
    logic [CLS_N-1:0][LC_W-1:0]             sort_cnt;
    logic [CLS_N-1:0][LANES-1:0][PAY_W-1:0] sort_data;
    logic [LANES-1:0]                       bad_lane;
    logic                                   accept;
    logic [CLS_N-1:0][POPC_W-1:0]           cls_pop;

    logic [CNT_W-1:0] q_count [THREADS][CLS_N];
    logic [CNT_W-1:0] q_free  [THREADS][CLS_N];
    logic [PAY_W-1:0] q_head  [THREADS][CLS_N][MAX_POP];

    // Unpack the flat lane buses.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign s_cls[l] = wr_class[l*CLS_W +: CLS_W];
        assign s_pay[l] = wr_payload[l*PAY_W +: PAY_W];
    end

    ibuf_enq_sorter #(.LANES(LANES), .PAY_W(PAY_W)) u_sort (
        .lane_vld (wr_mask),
        .lane_cls (s_cls),
        .lane_pay (s_pay),
        .cls_cnt  (sort_cnt),
        .cls_data (sort_data),
        .bad_lane (bad_lane)
    );

    // Whole-group admission: every class share must fit in the writer's queue, and no flush.
    always_comb begin
        wr_ready = !flush[wr_tid];
        for (int c = 0; c < CLS_N; c++) begin
            if (CNT_W'(sort_cnt[c]) > q_free[wr_tid][c])
                wr_ready = 1'b0;
        end
    end

    assign accept       = wr_valid && wr_ready;
    assign wr_bad_class = accept && (|bad_lane);

    // Count the consumed ports of each class of the read thread.
    always_comb begin
        for (int c = 0; c < CLS_N; c++) begin
            cls_pop[c] = '0;
            for (int k = 0; k < cls_ports(c); k++) begin
                if (rd_take[cls_base(c) + k] && rd_valid[cls_base(c) + k])
                    cls_pop[c] = cls_pop[c] + 1'b1;
            end
        end
    end

    // One queue per thread and class, sized to that class's issue width.
    for (genvar t = 0; t < THREADS; t++) begin : g_thr
        for (genvar c = 0; c < CLS_N; c++) begin : g_cls
            localparam int NP = cls_ports(c);
            logic [NP-1:0][PAY_W-1:0] head;
            logic [LC_W-1:0]          push_n;
            logic [POPC_W-1:0]        pop_n;

            assign push_n = (accept && wr_tid == TID_W'(t)) ? sort_cnt[c] : '0;
            assign pop_n  = (rd_tid == TID_W'(t)) ? cls_pop[c] : '0;

            ibuf_class_queue #(
                .DEPTH (DEPTH),
                .PAY_W (PAY_W),
                .PUSH_N(LANES),
                .POP_N (NP),
                .POPC_W(POPC_W)
            ) u_q (
                .clk      (clk),
                .rst_n    (rst_n),
                .flush    (flush[t]),
                .push_cnt (push_n),
                .push_data(sort_data[c]),
                .pop_cnt  (pop_n),
                .head_data(head),
                .count    (q_count[t][c]),
                .free     (q_free[t][c])
            );

            for (genvar k = 0; k < MAX_POP; k++) begin : g_pad
                if (k < NP) begin : g_real
                    assign q_head[t][c][k] = head[k];
                end else begin : g_zero
                    assign q_head[t][c][k] = '0;
                end
            end
        end
    end

    // Map the read thread's queue heads onto the class-grouped read ports.
    for (genvar c = 0; c < CLS_N; c++) begin : g_rport
        for (genvar k = 0; k < cls_ports(c); k++) begin : g_slot
            localparam int P = cls_base(c) + k;
            assign rd_valid[P]                  = q_count[rd_tid][c] > CNT_W'(k);
            assign rd_payload[P*PAY_W +: PAY_W] = q_head[rd_tid][c][k];
            if (k > 0) begin : g_pf
                AST_RD_PREFIX: assert property (@(posedge clk) disable iff (!rst_n) rd_valid[P] |-> rd_valid[P-1]);  // R4
            end
        end
    end

endmodule

// File: tb/ibuf_class_split_tb.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results at the falling edge.
module ibuf_class_split_tb;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         wr_valid;
    logic [0:0]   wr_tid;
    logic [5:0]   wr_mask;
    logic [17:0]  wr_class;
    logic [191:0] wr_payload;
    logic         wr_ready;
    logic         wr_bad_class;
    logic [0:0]   rd_tid;
    logic [11:0]  rd_take;
    logic [11:0]  rd_valid;
    logic [383:0] rd_payload;
    logic [1:0]   flush;

    int n_vec  = 0;
    int n_fail = 0;

    ibuf_class_split u_dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_tid(wr_tid), .wr_mask(wr_mask),
        .wr_class(wr_class), .wr_payload(wr_payload), .wr_ready(wr_ready),
        .wr_bad_class(wr_bad_class), .rd_tid(rd_tid), .rd_take(rd_take), .rd_valid(rd_valid),
        .rd_payload(rd_payload), .flush(flush)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int pbase(input int c);
        case (c)
            0: return 0;  1: return 2;  2: return 4;
            3: return 6;  4: return 8;  default: return 11;
        endcase
    endfunction

    function automatic logic [31:0] port_pay(input int p);
        return rd_payload[p*32 +: 32];
    endfunction

    task automatic idle();
        wr_valid = 1'b0; wr_tid = '0; wr_mask = '0; wr_class = '0; wr_payload = '0;
        rd_take = '0; flush = '0;
    endtask

    task automatic set_lane(input int l, input logic [2:0] cls, input logic [31:0] pay);
        wr_valid = 1'b1;
        wr_mask[l] = 1'b1;
        wr_class[l*3 +: 3] = cls;
        wr_payload[l*32 +: 32] = pay;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle();
        #0.5;
    endtask

    task automatic look(input logic [0:0] t);
        rd_tid = t;
        #0.5;
    endtask

    task automatic t_reset();
        look(1'b0); chk("R1 rd_valid t0", 32'(rd_valid), 32'h0);
        look(1'b1); chk("R1 rd_valid t1", 32'(rd_valid), 32'h0);
        chk("R1 wr_ready", 32'(wr_ready), 32'h1);
    endtask

    task automatic t_sort();
        wr_tid = 1'b0;
        for (int l = 0; l < 6; l++) set_lane(l, 3'(l), 32'h0A00_0000 + l);
        #0.5;
        chk("R6 ready on fitting group", 32'(wr_ready), 32'h1);
        chk("R7 no bad flag on legal group", 32'(wr_bad_class), 32'h0);
        step();
        look(1'b0);
        chk("R2 port map valid", 32'(rd_valid), 32'h955);
        for (int c = 0; c < 6; c++) chk("R2 class payload", port_pay(pbase(c)), 32'h0A00_0000 + c);
        look(1'b1);
        chk("R5 other thread empty", 32'(rd_valid), 32'h0);
    endtask

    task automatic t_order();
        wr_tid = 1'b0;
        for (int l = 0; l < 5; l++) set_lane(l, 3'd4, 32'h0B00_0000 + l);
        step();
        look(1'b0);
        chk("R3 branch oldest", port_pay(8), 32'h0A00_0004);
        chk("R4 branch next", port_pay(9), 32'h0B00_0000);
        chk("R3 branch third", port_pay(10), 32'h0B00_0001);
        chk("R4 branch ports valid", 32'(rd_valid[10:8]), 32'h7);
        // Pop two branch entries of thread 0 while thread 1 is written.
        rd_tid = 1'b0; rd_take = 12'h300;
        wr_tid = 1'b1; set_lane(0, 3'd0, 32'h1100_0000);
        step();
        look(1'b0);
        chk("R9 after pop port8", port_pay(8), 32'h0B00_0001);
        chk("R9 after pop port9", port_pay(9), 32'h0B00_0002);
        chk("R9 after pop port10", port_pay(10), 32'h0B00_0003);
        chk("R9 untaken memory kept", port_pay(0), 32'h0A00_0000);
        look(1'b1);
        chk("R5 concurrent write valid", 32'(rd_valid), 32'h001);
        chk("R5 concurrent write payload", port_pay(0), 32'h1100_0000);
    endtask

    task automatic t_illegal();
        wr_tid = 1'b1;
        set_lane(0, 3'd7, 32'hDEAD_0007);
        set_lane(1, 3'd1, 32'h1200_0001);
        set_lane(2, 3'd6, 32'hDEAD_0006);
        #0.5;
        chk("R7 bad flag", 32'(wr_bad_class), 32'h1);
        chk("R7 group accepted", 32'(wr_ready), 32'h1);
        step();
        chk("R7 flag drops with group", 32'(wr_bad_class), 32'h0);
        look(1'b1);
        chk("R7 only legal lane stored", 32'(rd_valid), 32'h005);
        chk("R7 legal payload", port_pay(2), 32'h1200_0001);
    endtask

    task automatic t_capacity();
        for (int g = 0; g < 2; g++) begin
            wr_tid = 1'b1;
            for (int l = 0; l < 6; l++) set_lane(l, 3'd5, 32'h1500_0000 + g*6 + l);
            #0.5;
            chk("R10 fill group accepted", 32'(wr_ready), 32'h1);
            step();
        end
        // 5 NOPs against 4 free slots, plus a memory lane that would fit.
        wr_tid = 1'b1;
        for (int l = 0; l < 5; l++) set_lane(l, 3'd5, 32'h1599_0000 + l);
        set_lane(5, 3'd0, 32'h1666_0000);
        #0.5;
        chk("R6 refused when one class short", 32'(wr_ready), 32'h0);
        step();
        wr_tid = 1'b1;
        for (int l = 0; l < 4; l++) set_lane(l, 3'd5, 32'h1500_000C + l);
        #0.5;
        chk("R10 exact fill accepted", 32'(wr_ready), 32'h1);
        step();
        wr_tid = 1'b1;
        set_lane(0, 3'd5, 32'h1599_00FF);
        #0.5;
        chk("R10 seventeenth refused", 32'(wr_ready), 32'h0);
        step();
        for (int i = 0; i < 16; i++) begin
            rd_tid = 1'b1; rd_take = 12'h800;
            #0.5;
            chk("R3 NOP drain valid", 32'(rd_valid[11]), 32'h1);
            chk("R10 NOP drain order", port_pay(11), 32'h1500_0000 + i);
            step();
        end
        look(1'b1);
        chk("R10 NOP queue empty after 16", 32'(rd_valid[11]), 32'h0);
        chk("R6 memory lane of refused group absent", 32'(rd_valid[1:0]), 32'h1);
        chk("R6 memory head unchanged", port_pay(0), 32'h1100_0000);
    endtask

    task automatic t_flush();
        flush = 2'b01;
        wr_tid = 1'b0; set_lane(0, 3'd1, 32'h0C00_0000);
        #0.5;
        chk("R8 write refused during flush", 32'(wr_ready), 32'h0);
        step();
        look(1'b0);
        chk("R8 flushed thread empty", 32'(rd_valid), 32'h0);
        look(1'b1);
        chk("R8 other thread kept", 32'(rd_valid), 32'h005);
        chk("R8 other thread payload", port_pay(2), 32'h1200_0001);
        wr_tid = 1'b0; set_lane(0, 3'd3, 32'h0D00_0000);
        step();
        look(1'b0);
        chk("R8 refill valid", 32'(rd_valid), 32'h040);
        chk("R8 refill payload", port_pay(6), 32'h0D00_0000);
    endtask

    initial begin
        #(200000 * 5);
        n_vec++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        idle();
        rd_tid = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        t_reset();
        t_sort();
        t_order();
        t_illegal();
        t_capacity();
        t_flush();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule